// File: doc/BRIEF.md
# Three-Input Lookup-Table Logic Unit

This block is a registered bitwise logic unit for an integer datapath. In its table mode it applies any of the 256 Boolean functions of three inputs to three operands. The function is named by an 8-bit truth table, and the same table is applied independently at every bit position. In its two-input mode it combines the first two operands with AND, OR, XOR or a pass-through of the second operand. Either of those two operands may be inverted before the operation.

The result is registered and appears one clock after the inputs are presented. A flag-write enable decides whether the zero and sign flags take their new values from that same result or keep the values they already hold. Both modes run on one shared per-bit table-select datapath. In two-input mode the requested operation and inversions are first turned into an equivalent 8-entry table.

Top module: `lut3_logic_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result`, `zero_flag` and `sign_flag` all become 0 at that edge.
- R2: With `mode_sel` = 1 (table mode), `result` bit i after the next rising edge equals `truth_tbl[4*opnd_a[i] + 2*opnd_b[i] + opnd_c[i]]`. Operand A is the most significant index bit.
- R3: In table mode, a table of 8'h00 gives an all-zero result and 8'hFF gives an all-ones result, whatever the operand values.
- R4: Table entry 4 is the only entry selected where A=1, B=0, C=0, and table entry 1 is the only entry selected where A=0, B=0, C=1. So 8'h10 yields A&~B&~C and 8'h02 yields ~A&~B&C.
- R5: With `mode_sel` = 0 (two-input mode), `op_sel` selects the operation: 0 gives A AND B, 1 gives A OR B, 2 gives A XOR B, 3 gives B. In this mode `opnd_c` and `truth_tbl` have no effect on the result.
- R6: In two-input mode, `inv_a` = 1 replaces A by ~A and `inv_b` = 1 replaces B by ~B before the operation. In table mode both inversion inputs have no effect.
- R7: When `flag_we` = 1, at the edge that loads the new result, `zero_flag` becomes 1 exactly when all result bits are 0, and `sign_flag` becomes the result's most significant bit.
- R8: When `flag_we` = 0, `zero_flag` and `sign_flag` keep their previous values while `result` still updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | 1 = three-input table mode, 0 = two-input mode |
| op_sel | input | 2 | Two-input operation: 0 AND, 1 OR, 2 XOR, 3 pass B |
| inv_a | input | 1 | Invert operand A in two-input mode |
| inv_b | input | 1 | Invert operand B in two-input mode |
| truth_tbl | input | 8 | Truth table for table mode |
| opnd_a | input | DATA_W | Operand A |
| opnd_b | input | DATA_W | Operand B |
| opnd_c | input | DATA_W | Operand C |
| flag_we | input | 1 | Update zero and sign flags from the new result |
| result | output | DATA_W | Registered logic result |
| zero_flag | output | 1 | Registered zero flag |
| sign_flag | output | 1 | Registered sign flag |

## Verification
Two things happen at the same clock edge: the result register loads a new value, and the flag registers either follow that value or hold. The bench first writes the flags from a zero result. It then presents an operand set with the sign bit set while `flag_we` is low. It checks that `result` changes in that cycle while both flags keep their older values, and that raising `flag_we` on the next vector makes the flags catch up with the result. The assertions check the same pairing: a flag write must match the result loaded alongside it, and a flag hold must leave the flags stable.

// File: rtl/lut3_logic_pkg.sv
package lut3_logic_pkg;

    localparam int TBL_W   = 8;
    localparam int IDX_W   = $clog2(TBL_W);

    typedef enum logic {
        MODE_TWO_IN = 1'b0,
        MODE_TABLE  = 1'b1
    } lu_mode_e;

    typedef enum logic [1:0] {
        OP_AND  = 2'd0,
        OP_OR   = 2'd1,
        OP_XOR  = 2'd2,
        OP_PASS = 2'd3
    } lu_op_e;

    typedef struct packed {
        lu_mode_e mode;
        lu_op_e   op;
        logic     inv_a;
        logic     inv_b;
    } lu_ctrl_t;

    typedef logic [TBL_W-1:0] lu_table_t;

    // Evaluates one two-input operation on single bits.
    function automatic logic apply_op(lu_op_e op, logic x, logic y);
        logic r;
        unique case (op)
            OP_AND:  r = x & y;
            OP_OR:   r = x | y;
            OP_XOR:  r = x ^ y;
            default: r = y;
        endcase
        return r;
    endfunction

    // Expresses a two-input operation with optional inversions as an
    // equivalent three-input table; the C index bit is a don't-care.
    function automatic lu_table_t two_input_table(lu_op_e op, logic inv_a, logic inv_b);
        lu_table_t        t;
        logic [IDX_W-1:0] ix;
        logic             av;
        logic             bv;
        t = '0;
        for (int k = 0; k < TBL_W; k++) begin
            ix   = k[IDX_W-1:0];
            av   = ix[2] ^ inv_a;
            bv   = ix[1] ^ inv_b;
            t[k] = apply_op(op, av, bv);
        end
        return t;
    endfunction

endpackage

// File: rtl/lut3_table_select.sv
module lut3_table_select
    import lut3_logic_pkg::*;
(
    input  lu_ctrl_t  ctrl,
    input  lu_table_t user_tbl,
    output lu_table_t eff_tbl
);
    lu_table_t folded_tbl;

    always_comb begin
        folded_tbl = two_input_table(ctrl.op, ctrl.inv_a, ctrl.inv_b);
        eff_tbl    = (ctrl.mode == MODE_TABLE) ? user_tbl : folded_tbl;
    end
endmodule

// File: rtl/lut3_bit_array.sv
module lut3_bit_array
    import lut3_logic_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  lu_table_t         tbl,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] c,
    output logic [DATA_W-1:0] y
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        logic [IDX_W-1:0] sel;
        assign sel  = {a[i], b[i], c[i]};
        assign y[i] = tbl[sel];
    end
endmodule

// File: rtl/lut3_flag_gen.sv
module lut3_flag_gen #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] value,
    output logic              is_zero,
    output logic              is_neg
);
    localparam int MSB = DATA_W - 1;

    assign is_zero = ~(|value);
    assign is_neg  = value[MSB];
endmodule

// File: rtl/lut3_logic_unit.sv
module lut3_logic_unit
    import lut3_logic_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_sel,
    input  logic [1:0]        op_sel,
    input  logic              inv_a,
    input  logic              inv_b,
    input  logic [7:0]        truth_tbl,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] opnd_c,
    input  logic              flag_we,
    output logic [DATA_W-1:0] result,
    output logic              zero_flag,
    output logic              sign_flag
);
    lu_ctrl_t          ctrl;
    lu_table_t         eff_tbl;
    logic [DATA_W-1:0] comb_y;
    logic              nxt_zero;
    logic              nxt_sign;

    assign ctrl.mode  = lu_mode_e'(mode_sel);
    assign ctrl.op    = lu_op_e'(op_sel);
    assign ctrl.inv_a = inv_a;
    assign ctrl.inv_b = inv_b;

    lut3_table_select u_tsel (
        .ctrl     (ctrl),
        .user_tbl (truth_tbl),
        .eff_tbl  (eff_tbl)
    );

    lut3_bit_array #(.DATA_W(DATA_W)) u_bits (
        .tbl (eff_tbl),
        .a   (opnd_a),
        .b   (opnd_b),
        .c   (opnd_c),
        .y   (comb_y)
    );

    lut3_flag_gen #(.DATA_W(DATA_W)) u_flags (
        .value   (comb_y),
        .is_zero (nxt_zero),
        .is_neg  (nxt_sign)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result    <= '0;
            zero_flag <= 1'b0;
            sign_flag <= 1'b0;
        end else begin
            result <= comb_y;
            if (flag_we) begin
                zero_flag <= nxt_zero;
                sign_flag <= nxt_sign;
            end
        end
    end
endmodule

// File: rtl/lut3_logic_unit_chk.sv
module lut3_logic_unit_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              mode_sel,
    input logic [1:0]        op_sel,
    input logic              inv_b,
    input logic [7:0]        truth_tbl,
    input logic [DATA_W-1:0] opnd_b,
    input logic              flag_we,
    input logic [DATA_W-1:0] result,
    input logic              zero_flag,
    input logic              sign_flag
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (result == '0 && !zero_flag && !sign_flag));

    // R7
    zero_follow_chk: assert property (@(posedge clk) disable iff (rst)
        flag_we |=> (zero_flag == (result == '0)));

    // R7
    sign_follow_chk: assert property (@(posedge clk) disable iff (rst)
        flag_we |=> (sign_flag == result[DATA_W-1]));

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !flag_we |=> ($stable(zero_flag) && $stable(sign_flag)));

    // R3
    table_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_sel && truth_tbl == 8'h00) |=> (result == '0));

    // R3
    table_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_sel && truth_tbl == 8'hFF) |=> (result == '1));

    // R5
    pass_b_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_sel && op_sel == 2'd3 && !inv_b) |=> (result == $past(opnd_b)));
endmodule

bind lut3_logic_unit lut3_logic_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_sel  (mode_sel),
    .op_sel    (op_sel),
    .inv_b     (inv_b),
    .truth_tbl (truth_tbl),
    .opnd_b    (opnd_b),
    .flag_we   (flag_we),
    .result    (result),
    .zero_flag (zero_flag),
    .sign_flag (sign_flag)
);

// File: tb/tb_lut3_logic_unit.sv
`timescale 1ns/1ps
module tb_lut3_logic_unit;
    localparam int W = 32;

    typedef struct packed {
        logic [3:0]   req;
        logic         mode;
        logic [1:0]   op;
        logic         ia;
        logic         ib;
        logic [7:0]   tbl;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] c;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{4'd2, 1'b1, 2'd0, 1'b0, 1'b0, 8'hE8, 32'hF0F0F0F0, 32'hCCCCCCCC, 32'hAAAAAAAA}, // R2 majority
        '{4'd2, 1'b1, 2'd0, 1'b0, 1'b0, 8'h96, 32'h12345678, 32'h9ABCDEF0, 32'h0F1E2D3C}, // R2 xor3
        '{4'd3, 1'b1, 2'd0, 1'b0, 1'b0, 8'h00, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF}, // R3 zeros
        '{4'd3, 1'b1, 2'd0, 1'b0, 1'b0, 8'hFF, 32'h00000000, 32'h00000000, 32'h00000000}, // R3 ones
        '{4'd4, 1'b1, 2'd0, 1'b0, 1'b0, 8'h10, 32'hF0F0F0F0, 32'hCCCCCCCC, 32'hAAAAAAAA}, // R4 entry 4
        '{4'd4, 1'b1, 2'd0, 1'b0, 1'b0, 8'h02, 32'hF0F0F0F0, 32'hCCCCCCCC, 32'hAAAAAAAA}, // R4 entry 1
        '{4'd5, 1'b0, 2'd0, 1'b0, 1'b0, 8'h5A, 32'hFF00FF00, 32'hF0F0F0F0, 32'h13579BDF}, // R5 AND
        '{4'd6, 1'b0, 2'd1, 1'b1, 1'b0, 8'hC3, 32'hFF00FF00, 32'h0F0F0F0F, 32'h2468ACE0}, // R6 OR ~A
        '{4'd6, 1'b0, 2'd2, 1'b0, 1'b1, 8'h00, 32'hDEADBEEF, 32'h01234567, 32'hFFFFFFFF}, // R6 XOR ~B
        '{4'd5, 1'b0, 2'd3, 1'b1, 1'b1, 8'hFF, 32'h55555555, 32'h89ABCDEF, 32'h00000000}, // R5 pass ~B
        '{4'd6, 1'b1, 2'd0, 1'b1, 1'b1, 8'hE8, 32'hF0F0F0F0, 32'hCCCCCCCC, 32'hAAAAAAAA}  // R6 ignored
    };

    logic         clk = 1'b0;
    logic         rst;
    logic         mode_sel;
    logic [1:0]   op_sel;
    logic         inv_a, inv_b;
    logic [7:0]   truth_tbl;
    logic [W-1:0] opnd_a, opnd_b, opnd_c;
    logic         flag_we;
    logic [W-1:0] result;
    logic         zero_flag, sign_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lut3_logic_unit #(.DATA_W(W)) dut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .op_sel(op_sel),
        .inv_a(inv_a), .inv_b(inv_b), .truth_tbl(truth_tbl),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c),
        .flag_we(flag_we), .result(result),
        .zero_flag(zero_flag), .sign_flag(sign_flag)
    );

    function automatic logic [W-1:0] model(vec_t v);
        logic [W-1:0] r, x, y;
        if (v.mode) begin
            for (int i = 0; i < W; i++) r[i] = v.tbl[{v.a[i], v.b[i], v.c[i]}];
        end else begin
            x = v.ia ? ~v.a : v.a;
            y = v.ib ? ~v.b : v.b;
            case (v.op)
                2'd0:    r = x & y;
                2'd1:    r = x | y;
                2'd2:    r = x ^ y;
                default: r = y;
            endcase
        end
        return r;
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(vec_t v, logic we);
        @(negedge clk);
        mode_sel = v.mode; op_sel = v.op; inv_a = v.ia; inv_b = v.ib;
        truth_tbl = v.tbl; opnd_a = v.a; opnd_b = v.b; opnd_c = v.c;
        flag_we = we;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        vec_t v;
        logic [W-1:0] r0;
        rst = 1'b1; mode_sel = 1'b1; op_sel = 2'd0; inv_a = 1'b0; inv_b = 1'b0;
        truth_tbl = 8'hFF; opnd_a = '1; opnd_b = '1; opnd_c = '1; flag_we = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state despite active inputs
        check("R1 result", result, '0);
        check("R1 zero_flag", {31'd0, zero_flag}, 32'd0);
        check("R1 sign_flag", {31'd0, sign_flag}, 32'd0);
        rst = 1'b0;

        // Vector walk (R2..R6), with R7 flag checks on each
        for (int k = 0; k < NV; k++) begin
            v = VECS[k];
            drive(v, 1'b1);
            check($sformatf("R%0d vec%0d result", v.req, k), result, model(v));
            check($sformatf("R7 vec%0d zero", k), {31'd0, zero_flag},
                  {31'd0, model(v) == '0});
            check($sformatf("R7 vec%0d sign", k), {31'd0, sign_flag},
                  {31'd0, model(v)[W-1]});
        end

        // R5: opnd_c and truth_tbl have no effect in two-input mode
        v = '{4'd5, 1'b0, 2'd2, 1'b0, 1'b0, 8'h00, 32'hA5A5A5A5, 32'h0FF00FF0, 32'h00000000};
        drive(v, 1'b0);
        r0 = result;
        v.c = 32'hFFFFFFFF; v.tbl = 8'hFF;
        drive(v, 1'b0);
        check("R5 C/table ignored", result, r0);
        check("R5 xor value", result, 32'hA5A5A5A5 ^ 32'h0FF00FF0);

        // R8: flags hold while result changes
        v = '{4'd3, 1'b1, 2'd0, 1'b0, 1'b0, 8'h00, 32'h1, 32'h2, 32'h3};
        drive(v, 1'b1);
        check("R7 zero set", {31'd0, zero_flag}, 32'd1);
        check("R7 sign clear", {31'd0, sign_flag}, 32'd0);
        v = '{4'd8, 1'b1, 2'd0, 1'b0, 1'b0, 8'hFF, 32'h0, 32'h0, 32'h0};
        drive(v, 1'b0);
        check("R8 result updates", result, 32'hFFFFFFFF);
        check("R8 zero held", {31'd0, zero_flag}, 32'd1);
        check("R8 sign held", {31'd0, sign_flag}, 32'd0);
        drive(v, 1'b1);
        check("R7 zero catches up", {31'd0, zero_flag}, 32'd0);
        check("R7 sign catches up", {31'd0, sign_flag}, 32'd1);

        // R1: reset again after activity
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 result after rerun", result, '0);
        check("R1 sign after rerun", {31'd0, sign_flag}, 32'd0);
        rst = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule